// File: doc/BRIEF.md
# Quad Double-Buffered DAC Register Controller

This block sits behind a two-wire serial slave and turns the received write bytes into register operations for four converter channels. Each channel has a 12-bit staging (input) register, a 12-bit live (DAC) register whose value goes to the analog converter, and a 2-bit power-down mode select. The slave front end tells the block when a write frame begins, hands it each received byte, marks the falling clock edge of every acknowledge slot, and reports the end of the frame.

A command is two bytes. The first byte has a 4-bit operation code in its upper nibble and the top four code bits in its lower nibble. The second byte has the low eight code bits. The block acts only at the acknowledge edge of the second byte, so a frame cut short earlier leaves every register as it was. Operations can stage a value without touching the outputs. They can load one channel and move all staged values live together. They can move all staged values live and then stage a new one, or load every channel at once. An extended form writes power-down modes to any chosen set of channels. A 16-bit read word echoes the last operation code with the live value of the last channel that was addressed.

Top module: `dacq_regctl`

## Requirements
- R1: After reset every input and DAC register is 0, every channel's mode is 11 (100 k to ground), and `rd_word` is 0.
- R2: Registers change only at an `ack_fall` pulse that arrives after the second byte of a command has been received. In `dac_codes`, channel A is bits [11:0], B is [23:12], C is [35:24] and D is [47:36]. In the first byte, bits 7:4 are the operation and bits 3:0 are code bits 11:8; the second byte is code bits 7:0.
- R3: Operations 0000–0011 (low two bits choose A=0 to D=3) write the code into that channel's input and DAC registers. In the same step, every other channel's DAC register takes its input register.
- R4: Operations 0100–0111 write the code into the chosen channel's input register only. No DAC output changes.
- R5: Operations 1000–1011 copy all four old input registers into the DAC registers, then write the code into the chosen channel's input register only.
- R6: Operation 1100 writes the code into every input and DAC register. Operation 1101 writes it into every input register only.
- R7: Operation 1111 with code bits 11:8 = 0 is the extended command. In its second byte, bit 2 selects A, bit 3 selects B, bit 4 selects C and bit 5 selects D. Bits 1:0 give the mode: 00 active, 01 high impedance, 10 1 k to ground, 11 100 k to ground. Each selected channel takes that mode. In `pd_modes`, channel A is bits [1:0], up to D at [7:6].
- R8: A mode change leaves every DAC code intact, so waking a channel restores its old value. Data operations never change a mode.
- R9: `frame_end`, or a new `wr_begin`, arriving before the committing acknowledge discards the partial command.
- R10: After a commit, the next two bytes in the same frame form a new command without a new `wr_begin`.
- R11: Operation 1110, and 1111 with nonzero code bits 11:8, change no register and leave `rd_word` unchanged.
- R12: `rd_word` is {last operation, DAC code of last addressed channel}. Single-channel operations update both fields. Operations 1100 and 1101 update only the operation field. The extended command updates neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_begin | input | 1 | Pulse: a write frame to this block has started |
| frame_end | input | 1 | Pulse: frame ended (stop or abort) |
| byte_vld | input | 1 | Pulse: `byte_in` holds a received byte |
| byte_in | input | 8 | Received data byte |
| ack_fall | input | 1 | Pulse: falling clock edge in the acknowledge slot of the latest byte |
| dac_codes | output | 48 | Live codes, channel A in the low 12 bits |
| pd_modes | output | 8 | Power-down mode per channel, A in the low 2 bits |
| rd_word | output | 16 | Read-back word |

## Verification
The bench targets the update-then-stage operation, where a design that stages first would push the new value live at once. It also checks the load-and-update operation, where a design that skips moving the other staged values would leave their outputs stale. Frames are aborted after one byte, after two bytes without the acknowledge, and by a repeated start; an eager design would commit garbage in each case, and a stale byte count would shift the next command's fields. Extended writes use partial masks, where a wrong bit order would switch off the wrong channel. A mid-run reset is followed by an update-all, which would expose staged values that survived the reset.

// File: rtl/dacq_pkg.sv
// Package: shared constants and types for the quad DAC register controller.
// Assumes a fixed two-byte command format: 4-bit operation + 12-bit code.
package dacq_pkg;
    localparam int CH_N     = 4;
    localparam int CODE_W   = 12;
    localparam int OP_W     = 4;
    localparam int PD_W     = 2;
    localparam int BYTE_W   = 8;
    localparam int CH_IDX_W = $clog2(CH_N);
    localparam int EXT_W    = CH_N + PD_W;
    localparam int RD_W     = OP_W + CODE_W;

    // Source selected for a DAC register on a commit.
    typedef enum logic [1:0] {
        DSRC_HOLD  = 2'd0,
        DSRC_DATA  = 2'd1,
        DSRC_INPUT = 2'd2
    } dsrc_e;

    // Power-down mode encoding.
    typedef enum logic [PD_W-1:0] {
        PD_ACTIVE = 2'd0,
        PD_HIZ    = 2'd1,
        PD_R1K    = 2'd2,
        PD_R100K  = 2'd3
    } pdm_e;

    // An assembled command.
    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [CODE_W-1:0] code;
    } cmd_t;
endpackage

// File: rtl/dacq_frame.sv
// Module: dacq_frame
// Collects the two data bytes of a command and raises cmd_vld at the
// acknowledge edge that follows the second byte. A frame boundary clears
// any partial command. Assumes byte_vld and ack_fall are single-cycle pulses.
module dacq_frame
    import dacq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_begin,
    input  logic              frame_end,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ack_fall,
    output logic              cmd_vld,
    output cmd_t              cmd
);
    localparam int          CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(2);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              boundary;

    assign boundary = wr_begin || frame_end;
    assign cmd_vld  = ack_fall && (cnt_q == CNT_FULL) && !boundary;
    assign cmd.op   = hi_q[BYTE_W-1 -: OP_W];
    assign cmd.code = {hi_q[OP_W-1:0], lo_q};

    // Byte counter: advance on bytes, clear on commit or frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (boundary) begin
            cnt_q <= '0;
        end else if (byte_vld && (cnt_q != CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (cmd_vld) begin
            cnt_q <= '0;
        end
    end

    // Byte capture: the first byte goes high, the second goes low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (byte_vld && !boundary) begin
            if (cnt_q == '0)           hi_q <= byte_in;
            else if (cnt_q == CNT_W'(1)) lo_q <= byte_in;
        end
    end

    // A frame boundary always leaves the counter empty.
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cnt_q == '0));

    // A commit never fires before two bytes have been received.
    p_commit_after_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_FULL) |-> !cmd_vld);
endmodule

// File: rtl/dacq_decode.sv
// Module: dacq_decode
// Combinational decode of a committed command into per-channel controls:
// input-register load enables, DAC-register sources and power-down writes.
// Assumes exactly four channels, matching the 2-bit channel field.
module dacq_decode
    import dacq_pkg::*;
(
    input  logic                cmd_vld,
    input  logic [OP_W-1:0]     op,
    input  logic [OP_W-1:0]     code_hi,
    input  logic [EXT_W-1:0]    ext_bits,
    output logic [CH_N-1:0]     in_ld,
    output dsrc_e               dsrc [CH_N],
    output logic [CH_N-1:0]     pd_we,
    output logic [PD_W-1:0]     pd_new,
    output logic                rd_op_we,
    output logic                rd_ch_we
);
    logic [CH_IDX_W-1:0] sel;
    logic                single;

    assign sel    = op[CH_IDX_W-1:0];
    assign single = (op[OP_W-1 -: 2] != 2'b11);
    assign pd_new = ext_bits[PD_W-1:0];

    // Read-word field updates: single-channel ops set both, broadcasts set the op.
    always_comb begin
        rd_ch_we = cmd_vld && single;
        rd_op_we = cmd_vld && (single || (op[1] == 1'b0));
    end

    // Per-channel control decode by operation group.
    always_comb begin
        in_ld = '0;
        pd_we = '0;
        for (int i = 0; i < CH_N; i++) dsrc[i] = DSRC_HOLD;
        if (cmd_vld) begin
            unique case (op[OP_W-1 -: 2])
                2'b00: begin
                    for (int i = 0; i < CH_N; i++) begin
                        in_ld[i] = (sel == CH_IDX_W'(i));
                        dsrc[i]  = (sel == CH_IDX_W'(i)) ? DSRC_DATA : DSRC_INPUT;
                    end
                end
                2'b01: begin
                    for (int i = 0; i < CH_N; i++) in_ld[i] = (sel == CH_IDX_W'(i));
                end
                2'b10: begin
                    for (int i = 0; i < CH_N; i++) begin
                        in_ld[i] = (sel == CH_IDX_W'(i));
                        dsrc[i]  = DSRC_INPUT;
                    end
                end
                default: begin
                    unique case (op[1:0])
                        2'b00: begin
                            in_ld = '1;
                            for (int i = 0; i < CH_N; i++) dsrc[i] = DSRC_DATA;
                        end
                        2'b01: in_ld = '1;
                        2'b11: begin
                            if (code_hi == '0) pd_we = ext_bits[PD_W +: CH_N];
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/dacq_chan.sv
// Module: dacq_chan
// One channel: staging register, live register and power-down mode.
// The live register may take new data or the pre-commit staged value.
// Assumes controls are valid only in the commit cycle.
module dacq_chan
    import dacq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_ld,
    input  dsrc_e             dsrc,
    input  logic              pd_we,
    input  logic [PD_W-1:0]   pd_new,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] dac_q,
    output logic [PD_W-1:0]   pd_q
);
    logic [CODE_W-1:0] in_q;

    // Staging register load.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_q <= '0;
        else if (in_ld) in_q <= data;
    end

    // Live register update from data or the old staged value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= '0;
        end else begin
            unique case (dsrc)
                DSRC_DATA:  dac_q <= data;
                DSRC_INPUT: dac_q <= in_q;
                default:    ;
            endcase
        end
    end

    // Power-down mode register; resets to the 100 k termination.
    always_ff @(posedge clk) begin
        if (!rst_n)     pd_q <= PD_R100K;
        else if (pd_we) pd_q <= pd_new;
    end
endmodule

// File: rtl/dacq_regctl.sv
// Module: dacq_regctl (top)
// Command and register layer for a four-channel double-buffered DAC.
// Assembles two-byte commands, decodes them, updates the channel registers
// and forms the read-back word. Assumes the slave front end supplies the
// frame, byte and acknowledge-edge pulses synchronous to clk.
module dacq_regctl
    import dacq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_begin,
    input  logic                 frame_end,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_in,
    input  logic                 ack_fall,
    output logic [47:0]          dac_codes,
    output logic [7:0]           pd_modes,
    output logic [15:0]          rd_word
);
    logic                cmd_vld;
    cmd_t                cmd;
    logic [CH_N-1:0]     in_ld;
    dsrc_e               dsrc [CH_N];
    logic [CH_N-1:0]     pd_we;
    logic [PD_W-1:0]     pd_new;
    logic                rd_op_we;
    logic                rd_ch_we;
    logic [CODE_W-1:0]   code_w [CH_N];
    logic [PD_W-1:0]     pd_w   [CH_N];
    logic [OP_W-1:0]     last_op_q;
    logic [CH_IDX_W-1:0] last_ch_q;

    dacq_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_begin (wr_begin),
        .frame_end(frame_end),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .ack_fall (ack_fall),
        .cmd_vld  (cmd_vld),
        .cmd      (cmd)
    );

    dacq_decode u_decode (
        .cmd_vld (cmd_vld),
        .op      (cmd.op),
        .code_hi (cmd.code[CODE_W-1 -: OP_W]),
        .ext_bits(cmd.code[EXT_W-1:0]),
        .in_ld   (in_ld),
        .dsrc    (dsrc),
        .pd_we   (pd_we),
        .pd_new  (pd_new),
        .rd_op_we(rd_op_we),
        .rd_ch_we(rd_ch_we)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        dacq_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .in_ld (in_ld[g]),
            .dsrc  (dsrc[g]),
            .pd_we (pd_we[g]),
            .pd_new(pd_new),
            .data  (cmd.code),
            .dac_q (code_w[g]),
            .pd_q  (pd_w[g])
        );
        assign dac_codes[g*CODE_W +: CODE_W] = code_w[g];
        assign pd_modes[g*PD_W +: PD_W]      = pd_w[g];

        // Each selected channel takes the extended-command mode.
        p_ext_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_vld && cmd.op == 4'hF && cmd.code[11:8] == 4'h0 && cmd.code[PD_W+g])
            |=> (pd_w[g] == $past(cmd.code[PD_W-1:0])));
    end

    // Read-back bookkeeping: last operation and last addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_op_q <= '0;
            last_ch_q <= '0;
        end else begin
            if (rd_op_we) last_op_q <= cmd.op;
            if (rd_ch_we) last_ch_q <= cmd.op[CH_IDX_W-1:0];
        end
    end

    assign rd_word = {last_op_q, code_w[last_ch_q]};

    // Without a commit nothing visible moves.
    p_no_commit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> ($stable(dac_codes) && $stable(pd_modes)));

    // Single-channel operations stage into exactly one channel.
    p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd.op[3:2] != 2'b11) |-> ($countones(in_ld) == 1));

    // Mode writes keep the live codes.
    p_retain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd.op == 4'hF) |=> $stable(dac_codes));

    // The unused operation changes nothing visible.
    p_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd.op == 4'hE)
        |=> ($stable(dac_codes) && $stable(pd_modes) && $stable(rd_word)));
endmodule

// File: tb/dacq_regctl_tb_top.sv
// Bench for dacq_regctl: vector table walk, then directed corner cases.
module dacq_regctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_begin = 1'b0;
    logic        frame_end = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        ack_fall = 1'b0;
    logic [47:0] dac_codes;
    logic [7:0]  pd_modes;
    logic [15:0] rd_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dacq_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .frame_end(frame_end),
        .byte_vld(byte_vld), .byte_in(byte_in), .ack_fall(ack_fall),
        .dac_codes(dac_codes), .pd_modes(pd_modes), .rd_word(rd_word)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] data;
        logic [47:0] exp_dac;
        logic [15:0] exp_rd;
    } vec_t;

    // Walked from reset; pd_modes must stay 8'hFF throughout (R8).
    localparam vec_t VECS [11] = '{
        '{4'h4, 12'h111, 48'h000000000000, 16'h4000},  // R4
        '{4'h5, 12'h222, 48'h000000000000, 16'h5000},  // R4
        '{4'h2, 12'h333, 48'h000333222111, 16'h2333},  // R3
        '{4'h7, 12'h444, 48'h000333222111, 16'h7000},  // R4
        '{4'h8, 12'h555, 48'h444333222111, 16'h8111},  // R5
        '{4'h1, 12'h666, 48'h444333666555, 16'h1666},  // R3
        '{4'hD, 12'h777, 48'h444333666555, 16'hD666},  // R6 R12
        '{4'hE, 12'h888, 48'h444333666555, 16'hD666},  // R11
        '{4'hB, 12'h999, 48'h777777777777, 16'hB777},  // R5
        '{4'hC, 12'hABC, 48'hABCABCABCABC, 16'hCABC},  // R6
        '{4'hF, 12'h123, 48'hABCABCABCABC, 16'hCABC}   // R11
    };

    task automatic chk(input string req, input logic [47:0] got, input logic [47:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic pulse_begin();
        @(negedge clk) wr_begin = 1'b1;
        @(negedge clk) wr_begin = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk) frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit ack);
        @(negedge clk) begin byte_vld = 1'b1; byte_in = b; end
        @(negedge clk) byte_vld = 1'b0;
        if (ack) begin
            ack_fall = 1'b1;
            @(negedge clk) ack_fall = 1'b0;
        end
    endtask

    task automatic write_cmd(input logic [3:0] op, input logic [11:0] d);
        pulse_begin();
        send({op, d[11:8]}, 1'b1);
        send(d[7:0], 1'b1);
        pulse_end();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dac", dac_codes, 48'h0);
        chk("R1 pd", {40'h0, pd_modes}, 48'hFF);
        chk("R1 rd", {32'h0, rd_word}, 48'h0);

        // Vector walk (R3 R4 R5 R6 R11 R12, modes untouched R8)
        for (int i = 0; i < 11; i++) begin
            write_cmd(VECS[i].op, VECS[i].data);
            chk("R3-6 table dac", dac_codes, VECS[i].exp_dac);
            chk("R12 table rd", {32'h0, rd_word}, {32'h0, VECS[i].exp_rd});
            chk("R8 table pd", {40'h0, pd_modes}, 48'hFF);
        end

        // R7: wake A and C (mask bits 2 and 4), mode 00
        write_cmd(4'hF, 12'h014);
        chk("R7 mask A,C", {40'h0, pd_modes}, 48'hCC);
        chk("R8 codes kept", dac_codes, 48'hABCABCABCABC);
        chk("R12 ext leaves rd", {32'h0, rd_word}, 48'hCABC);
        // R7: all channels high impedance
        write_cmd(4'hF, 12'h03D);
        chk("R7 all hiz", {40'h0, pd_modes}, 48'h55);
        // R8: wake all, codes restored
        write_cmd(4'hF, 12'h03C);
        chk("R8 wake", {40'h0, pd_modes}, 48'h00);
        chk("R8 restore", dac_codes, 48'hABCABCABCABC);

        // R9: abort after one byte
        pulse_begin();
        send(8'h0F, 1'b1);
        pulse_end();
        chk("R9 abort one byte", dac_codes, 48'hABCABCABCABC);
        // R9/R2: two bytes but no acknowledge edge
        pulse_begin();
        send(8'h0F, 1'b1);
        send(8'hFF, 1'b0);
        pulse_end();
        chk("R2 no ack", dac_codes, 48'hABCABCABCABC);
        // R9: repeated start drops the partial byte, next command lands intact
        pulse_begin();
        send(8'h01, 1'b1);
        pulse_begin();
        send(8'h4F, 1'b1);
        send(8'hFF, 1'b1);
        pulse_end();
        chk("R9 restart dac", dac_codes, 48'hABCABCABCABC);
        chk("R9 restart rd", {32'h0, rd_word}, 48'h4ABC);
        write_cmd(4'h1, 12'h012);
        chk("R9 staged A", dac_codes, 48'hABCABC012FFF);

        // R10: two commands in one frame
        pulse_begin();
        send(8'h22, 1'b1);
        send(8'h34, 1'b1);
        chk("R10 first", dac_codes, 48'hABC234012FFF);
        send(8'h35, 1'b1);
        send(8'h67, 1'b1);
        pulse_end();
        chk("R10 second", dac_codes, 48'h567234012FFF);
        chk("R12 continuous rd", {32'h0, rd_word}, 48'h3567);

        // R1: mid-run reset clears staged values too
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rerst pd", {40'h0, pd_modes}, 48'hFF);
        chk("R1 rerst rd", {32'h0, rd_word}, 48'h0);
        write_cmd(4'h8, 12'h005);
        chk("R1 inputs cleared", dac_codes, 48'h0);
        chk("R12 after rerst", {32'h0, rd_word}, 48'h8000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule